// File: doc/BRIEF.md
# Word-Serial Register Access Bridge

This block lets a host reach a remote register space of 24-bit addresses through a single 32-bit transfer port and a small status register. The host writes a command word to the transfer port. The command carries an opcode and a register address. For a write access the host then writes one data word to the same port. The bridge runs the access on a simple internal register bus. When the result is ready, the bridge sets a ready flag.

The host then drains the response words from the transfer port. A read gives a status word and then the data word. A write gives only a status word. When the last pending word has been read, the ready flag drops and the bridge accepts a new command. Stale responses can be cleared by reading the port until ready is low. A command that arrives while a response or an access is still outstanding is dropped, and a sticky overrun bit records it.

Top module: `wordlink_bridge`

## Requirements
- R1: A transfer-port write whose bits 31:24 equal 0x01 starts a read. One cycle after that write, rb_req is high, rb_we is low and rb_addr equals bits 23:0 of the command word.
- R2: A command whose bits 31:24 equal 0x10 starts a write. The next transfer-port write is taken as the data word. In the cycle after the data word, rb_req and rb_we are high, rb_addr is the command address and rb_wdata is the data word.
- R3: rb_req is high for exactly one cycle per access. rb_rdata and rb_err are sampled in the following cycle.
- R4: Status register bit 0 is the ready flag. It rises in the cycle after the response is sampled, which is two cycles after rb_req.
- R5: After a read, the transfer port returns the status word first and the read data second. Each host read of the port consumes one word.
- R6: After a write, the transfer port returns exactly one word, the status word.
- R7: The status word is 0 when rb_err is low. It is 1 when rb_err is high, and in that case the read data word is returned as 0.
- R8: The ready flag clears once every pending word has been read. Reading the port repeatedly drains any stale response.
- R9: A command written while a response is pending or an access is in flight starts no access and leaves the queued response intact. It sets status register bit 1 (overrun). That bit stays set until the host reads the status register.
- R10: A transfer-port read with nothing pending returns 0 and changes no state.
- R11: A command with any other opcode starts no access and produces no response.
- R12: After reset, the ready flag, the overrun bit, rb_req and the transfer-port read value are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_wr_en | input | 1 | Host write strobe |
| h_rd_en | input | 1 | Host read strobe (consumes a word when the port is selected) |
| h_sel | input | 1 | 0 selects the transfer port, 1 selects the status register |
| h_wdata | input | 32 | Host write word |
| h_rdata | output | 32 | Selected register value (combinational) |
| rb_req | output | 1 | Internal bus request, one cycle |
| rb_we | output | 1 | Internal bus write enable |
| rb_addr | output | 24 | Internal bus register address |
| rb_wdata | output | 32 | Internal bus write data |
| rb_rdata | input | 32 | Internal bus read data, valid the cycle after rb_req |
| rb_err | input | 1 | No register at address, valid the cycle after rb_req |

## Verification
The bench uses the default response depth of two words. This is the minimum that holds a complete read reply, so the exact order of status and data is visible at the port. The bench attaches a model register file of sixteen words. Any address at 16 or above reports an error, which exercises the error status and the zeroed read data. The model returns garbage data on error, so the zeroing has to come from the bridge.

// File: rtl/wlb_pkg.sv
package wlb_pkg;
    localparam int OPC_W  = 8;
    localparam int ADDR_W = 24;
    localparam int WORD_W = 32;

    localparam logic [OPC_W-1:0]  OPC_READ  = 8'h01;
    localparam logic [OPC_W-1:0]  OPC_WRITE = 8'h10;
    localparam logic [WORD_W-1:0] STAT_OK    = '0;
    localparam logic [WORD_W-1:0] STAT_NOREG = WORD_W'(1);

    localparam int RDY_BIT = 0;
    localparam int OVR_BIT = 1;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_WDATA,
        SEQ_ISSUE,
        SEQ_WAIT
    } seq_state_e;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_READ,
        CMD_WRITE
    } cmd_kind_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
    } access_t;

    typedef struct packed {
        logic              two;
        logic [WORD_W-1:0] stat;
        logic [WORD_W-1:0] data;
    } resp_t;

    function automatic cmd_kind_e classify(input logic [WORD_W-1:0] w);
        case (w[WORD_W-1 -: OPC_W])
            OPC_READ:  return CMD_READ;
            OPC_WRITE: return CMD_WRITE;
            default:   return CMD_NONE;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] cmd_addr(input logic [WORD_W-1:0] w);
        return w[ADDR_W-1:0];
    endfunction
endpackage

// File: rtl/wlb_sequencer.sv
module wlb_sequencer
    import wlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              port_wr,
    input  logic [WORD_W-1:0] port_wdata,
    input  logic              resp_pending,
    output logic              issue,
    output logic              capture,
    output access_t           acc,
    output logic              ovr_set
);
    seq_state_e state;
    cmd_kind_e  kind;

    assign kind    = classify(port_wdata);
    assign issue   = (state == SEQ_ISSUE);
    assign capture = (state == SEQ_WAIT);
    assign ovr_set = port_wr &&
                     ((state == SEQ_IDLE && resp_pending) ||
                      state == SEQ_ISSUE || state == SEQ_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            acc   <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (port_wr && !resp_pending) begin
                        if (kind == CMD_READ) begin
                            acc.we    <= 1'b0;
                            acc.addr  <= cmd_addr(port_wdata);
                            acc.wdata <= '0;
                            state     <= SEQ_ISSUE;
                        end else if (kind == CMD_WRITE) begin
                            acc.we   <= 1'b1;
                            acc.addr <= cmd_addr(port_wdata);
                            state    <= SEQ_WDATA;
                        end
                    end
                end
                SEQ_WDATA: begin
                    if (port_wr) begin
                        acc.wdata <= port_wdata;
                        state     <= SEQ_ISSUE;
                    end
                end
                SEQ_ISSUE: state <= SEQ_WAIT;
                default:   state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wlb_rbus_master.sv
module wlb_rbus_master
    import wlb_pkg::*;
(
    input  logic              issue,
    input  logic              capture,
    input  access_t           acc,
    output logic              rb_req,
    output logic              rb_we,
    output logic [ADDR_W-1:0] rb_addr,
    output logic [WORD_W-1:0] rb_wdata,
    input  logic [WORD_W-1:0] rb_rdata,
    input  logic              rb_err,
    output logic              push,
    output resp_t             resp
);
    assign rb_req   = issue;
    assign rb_we    = acc.we;
    assign rb_addr  = acc.addr;
    assign rb_wdata = acc.wdata;

    assign push = capture;

    always_comb begin
        resp.two  = !acc.we;
        resp.stat = rb_err ? STAT_NOREG : STAT_OK;
        resp.data = rb_err ? '0 : rb_rdata;
    end
endmodule

// File: rtl/wlb_resp_queue.sv
module wlb_resp_queue
    import wlb_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  resp_t             resp,
    input  logic              pop,
    output logic [WORD_W-1:0] head,
    output logic              pending
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WORD_W-1:0] slot [DEPTH];
    logic [CNT_W-1:0]  cnt;

    assign pending = (cnt != '0);
    assign head    = slot[0];

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (push)
            cnt <= resp.two ? CNT_W'(2) : CNT_W'(1);
        else if (pop && pending)
            cnt <= cnt - CNT_W'(1);
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [WORD_W-1:0] load_val;
        logic [WORD_W-1:0] shift_val;

        if (i == 0) begin : g_first
            assign load_val = resp.stat;
        end else if (i == 1) begin : g_second
            assign load_val = resp.data;
        end else begin : g_rest
            assign load_val = '0;
        end

        if (i == DEPTH - 1) begin : g_tail
            assign shift_val = '0;
        end else begin : g_body
            assign shift_val = slot[i+1];
        end

        always_ff @(posedge clk) begin
            if (rst)
                slot[i] <= '0;
            else if (push)
                slot[i] <= load_val;
            else if (pop && pending)
                slot[i] <= shift_val;
        end
    end
endmodule

// File: rtl/wordlink_bridge.sv
module wordlink_bridge
    import wlb_pkg::*;
#(
    parameter int RESP_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              h_wr_en,
    input  logic              h_rd_en,
    input  logic              h_sel,
    input  logic [WORD_W-1:0] h_wdata,
    output logic [WORD_W-1:0] h_rdata,
    output logic              rb_req,
    output logic              rb_we,
    output logic [ADDR_W-1:0] rb_addr,
    output logic [WORD_W-1:0] rb_wdata,
    input  logic [WORD_W-1:0] rb_rdata,
    input  logic              rb_err
);
    logic              port_wr, port_rd, stat_rd;
    logic              issue, capture, ovr_set, push, ready, ovr;
    logic [WORD_W-1:0] head;
    access_t           acc;
    resp_t             resp;

    assign port_wr = h_wr_en && !h_sel;
    assign port_rd = h_rd_en && !h_sel;
    assign stat_rd = h_rd_en && h_sel;

    wlb_sequencer u_seq (
        .clk          (clk),
        .rst          (rst),
        .port_wr      (port_wr),
        .port_wdata   (h_wdata),
        .resp_pending (ready),
        .issue        (issue),
        .capture      (capture),
        .acc          (acc),
        .ovr_set      (ovr_set)
    );

    wlb_rbus_master u_mst (
        .issue    (issue),
        .capture  (capture),
        .acc      (acc),
        .rb_req   (rb_req),
        .rb_we    (rb_we),
        .rb_addr  (rb_addr),
        .rb_wdata (rb_wdata),
        .rb_rdata (rb_rdata),
        .rb_err   (rb_err),
        .push     (push),
        .resp     (resp)
    );

    wlb_resp_queue #(.DEPTH(RESP_DEPTH)) u_q (
        .clk     (clk),
        .rst     (rst),
        .push    (push),
        .resp    (resp),
        .pop     (port_rd),
        .head    (head),
        .pending (ready)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ovr <= 1'b0;
        else if (ovr_set)
            ovr <= 1'b1;
        else if (stat_rd)
            ovr <= 1'b0;
    end

    always_comb begin
        h_rdata = '0;
        if (h_sel) begin
            h_rdata[RDY_BIT] = ready;
            h_rdata[OVR_BIT] = ovr;
        end else if (ready) begin
            h_rdata = head;
        end
    end
endmodule

// File: rtl/wordlink_bridge_chk.sv
module wordlink_bridge_chk (
    input logic clk,
    input logic rst,
    input logic h_wr_en,
    input logic h_rd_en,
    input logic h_sel,
    input logic rb_req,
    input logic ready,
    input logic ovr
);
    // R3
    req_single_chk: assert property (@(posedge clk) disable iff (rst)
        rb_req |=> !rb_req);

    // R4
    ready_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(rb_req, 2));

    // R8
    ready_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ready) |-> $past(h_rd_en && !h_sel));

    // R9
    ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
        (h_wr_en && !h_sel && ready) |=> ovr);

    // R9
    no_issue_pending_chk: assert property (@(posedge clk) disable iff (rst)
        rb_req |-> !ready);
endmodule

bind wordlink_bridge wordlink_bridge_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .h_wr_en (h_wr_en),
    .h_rd_en (h_rd_en),
    .h_sel   (h_sel),
    .rb_req  (rb_req),
    .ready   (ready),
    .ovr     (ovr)
);

// File: tb/tb_wordlink_bridge.sv
`timescale 1ns/1ps
module tb_wordlink_bridge;
    logic        clk = 0;
    logic        rst = 1;
    logic        h_wr_en = 0, h_rd_en = 0, h_sel = 0;
    logic [31:0] h_wdata = '0;
    logic [31:0] h_rdata;
    logic        rb_req, rb_we;
    logic [23:0] rb_addr;
    logic [31:0] rb_wdata;
    logic [31:0] rsp_data;
    logic        rsp_err;

    int tests = 0, fails = 0, req_cnt = 0;
    bit done = 0;

    always #10 clk = ~clk;

    wordlink_bridge dut (
        .clk(clk), .rst(rst), .h_wr_en(h_wr_en), .h_rd_en(h_rd_en),
        .h_sel(h_sel), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .rb_req(rb_req), .rb_we(rb_we), .rb_addr(rb_addr),
        .rb_wdata(rb_wdata), .rb_rdata(rsp_data), .rb_err(rsp_err)
    );

    // Model register file: 16 words, addresses >= 16 report an error.
    logic [31:0] mem [16];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) mem[i] <= 32'hA500_0000 | i;
            rsp_err  <= 1'b0;
            rsp_data <= 32'hDEAD_BEEF;
        end else if (rb_req) begin
            req_cnt  <= req_cnt + 1;
            rsp_err  <= (rb_addr >= 24'd16);
            rsp_data <= (rb_addr < 24'd16) ? mem[rb_addr[3:0]] : 32'hDEAD_BEEF;
            if (rb_we && rb_addr < 24'd16) mem[rb_addr[3:0]] <= rb_wdata;
        end else begin
            rsp_err  <= 1'b0;
            rsp_data <= 32'hDEAD_BEEF;
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic hw(input logic sel, input logic [31:0] d);
        h_sel = sel; h_wdata = d; h_wr_en = 1;
        @(negedge clk);
        h_wr_en = 0;
    endtask

    task automatic hr(input logic sel, output logic [31:0] d);
        h_sel = sel; h_rd_en = 1;
        #1 d = h_rdata;
        @(negedge clk);
        h_rd_en = 0;
    endtask

    task automatic peek_stat(output logic [31:0] d);
        h_sel = 1; #1 d = h_rdata;
    endtask

    task automatic wait_rdy(output logic ok);
        logic [31:0] s;
        ok = 0;
        for (int n = 0; n < 20 && !ok; n++) begin
            peek_stat(s);
            if (s[0]) ok = 1;
            else @(negedge clk);
        end
    endtask

    typedef struct packed {
        logic        rd;
        logic [23:0] addr;
        logic [31:0] wd;
        logic [31:0] est;
        logic [31:0] ed;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{1'b1, 24'h000003, 32'h0,         32'h0, 32'hA500_0003},
        '{1'b0, 24'h000003, 32'h1234_5678, 32'h0, 32'h0},
        '{1'b1, 24'h000003, 32'h0,         32'h0, 32'h1234_5678},
        '{1'b0, 24'h000020, 32'h0BAD_0BAD, 32'h1, 32'h0},
        '{1'b1, 24'hABCDEF, 32'h0,         32'h1, 32'h0},
        '{1'b0, 24'h00000F, 32'hFFFF_0000, 32'h0, 32'h0},
        '{1'b1, 24'h00000F, 32'h0,         32'h0, 32'hFFFF_0000},
        '{1'b1, 24'h000000, 32'h0,         32'h0, 32'hA500_0000}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, s;
        logic ok;
        int base, nrd;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R12 reset state
        peek_stat(s); check("R12 status reg", s, 32'h0);
        check("R12 rb_req", {31'b0, rb_req}, 32'h0);
        h_sel = 0; #1 check("R12 port value", h_rdata, 32'h0);

        // Vector walk (R5 R6 R7 R8)
        for (int i = 0; i < 8; i++) begin
            if (VEC[i].rd) hw(0, {8'h01, VEC[i].addr});
            else begin hw(0, {8'h10, VEC[i].addr}); hw(0, VEC[i].wd); end
            wait_rdy(ok);
            check("R4 ready seen", {31'b0, ok}, 32'h1);
            hr(0, d);
            check(VEC[i].rd ? "R5 R7 read status" : "R6 R7 write status", d, VEC[i].est);
            if (VEC[i].rd) begin
                hr(0, d);
                check("R5 R7 read data", d, VEC[i].ed);
            end
            peek_stat(s);
            check("R8 ready cleared", s, 32'h0);
        end

        // R1 R3 R4 exact read timing
        hw(0, 32'h0100_0005);
        check("R1 rb_req", {31'b0, rb_req}, 32'h1);
        check("R1 rb_we", {31'b0, rb_we}, 32'h0);
        check("R1 rb_addr", {8'h0, rb_addr}, 32'h5);
        @(negedge clk);
        check("R3 req one cycle", {31'b0, rb_req}, 32'h0);
        peek_stat(s); check("R4 not yet ready", s, 32'h0);
        @(negedge clk);
        peek_stat(s); check("R4 ready timing", s, 32'h1);
        hr(0, d); check("R5 status first", d, 32'h0);
        peek_stat(s); check("R8 ready held", s, 32'h1);
        hr(0, d); check("R5 data second", d, 32'hA500_0005);
        peek_stat(s); check("R8 ready cleared", s, 32'h0);

        // R2 R6 write timing
        hw(0, 32'h1000_0007);
        check("R2 wait for data", {31'b0, rb_req}, 32'h0);
        hw(0, 32'h0000_55AA);
        check("R2 rb_req", {31'b0, rb_req}, 32'h1);
        check("R2 rb_we", {31'b0, rb_we}, 32'h1);
        check("R2 rb_addr", {8'h0, rb_addr}, 32'h7);
        check("R2 rb_wdata", rb_wdata, 32'h0000_55AA);
        repeat (2) @(negedge clk);
        peek_stat(s); check("R4 write ready", s, 32'h1);
        hr(0, d); check("R6 status", d, 32'h0);
        peek_stat(s); check("R6 single word", s, 32'h0);

        // R10 empty port read
        hr(0, d); check("R10 empty read value", d, 32'h0);
        peek_stat(s); check("R10 no side effect", s, 32'h0);

        // R9 overrun
        hw(0, 32'h0100_0001);
        wait_rdy(ok);
        base = req_cnt;
        hw(0, 32'h1000_0002);
        repeat (3) @(negedge clk);
        check("R9 no access", req_cnt, base);
        hr(1, s); check("R9 overrun flag", s, 32'h3);
        hr(1, s); check("R9 overrun cleared on read", s, 32'h1);
        hr(0, d); check("R9 queued status intact", d, 32'h0);
        hr(0, d); check("R9 queued data intact", d, 32'hA500_0001);

        // R9 command during in-flight access
        hw(0, 32'h0100_0004);
        hw(0, 32'h0100_0006);
        peek_stat(s); check("R9 in-flight overrun", s, 32'h2);
        wait_rdy(ok);
        hr(0, d); hr(0, d); check("R9 first access kept", d, 32'hA500_0004);
        hr(1, s); check("R9 ready after drain", s, 32'h2);

        // R8 drain loop
        hw(0, 32'h0100_0009);
        wait_rdy(ok);
        nrd = 0;
        peek_stat(s);
        while (s[0] && nrd < 10) begin hr(0, d); nrd++; peek_stat(s); end
        check("R8 drain count", nrd, 2);

        // R11 unknown opcode
        base = req_cnt;
        hw(0, 32'h3300_0004);
        repeat (4) @(negedge clk);
        check("R11 no access", req_cnt, base);
        peek_stat(s); check("R11 no response", s, 32'h0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule